// File: doc/BRIEF.md
# I2C Serial EEPROM Target Controller

This block is the bus-facing side of a small serial EEPROM. It watches an I2C bus through oversampled SCL and SDA inputs and pulls SDA low through an open-drain enable. It decodes START, repeated START and STOP conditions and checks the device header byte. It then runs write or read transactions against a byte memory that sits outside the block and is reached through a simple memory port.

Incoming write data is held in a one-page buffer. The buffer is committed to memory after the STOP, and a timed write cycle follows it. A counter stands in for the programming time. While that cycle runs, the target ignores the bus, so a master can poll for completion by sending headers until one is acknowledged. A single address pointer survives from one transaction to the next. Current-address reads, random reads and sequential reads all use it.

Top module: `eep_i2c_target`

## Requirements
- R1: A header byte is acknowledged only when its bits 7..4 equal 4'b1010. Bits 3..1 are don't-care. Bit 0 selects the direction, with 1 meaning read. Any other header gets no acknowledge, and the target stays silent until the next START.
- R2: Each accepted header, word address and write-data byte is acknowledged: the target drives SDA low through the ninth SCL pulse.
- R3: A write of one data byte followed by STOP stores that byte at the word address, once the internal write cycle completes.
- R4: In a write, the low PAGE_W bits of the pointer advance after each data byte and wrap within the page of 2^PAGE_W bytes. The upper bits do not change, so extra bytes overwrite earlier bytes of the same page.
- R5: A STOP with buffered data starts a write cycle of 2^PAGE_W + TWR_CYC clocks. During that cycle no header is acknowledged and SDA is never driven. After it, headers are acknowledged again.
- R6: A read header with no preceding word address returns the byte at the pointer. The pointer holds the last accessed address plus one.
- R7: A random read returns the byte at the loaded address. It consists of a write header, a word address, a repeated START and a read header.
- R8: After each byte sent, the pointer increments and wraps from the top of memory to 0. A master ACK (SDA low in the ninth pulse) makes the target send the next byte.
- R9: A master NACK after a read byte ends the read. The target releases SDA and waits for the next START or STOP.
- R10: A write transaction that carries only a word address and then a STOP loads the pointer but starts no write cycle. A header sent right after it is acknowledged.
- R11: The target changes its SDA drive only while SCL is low, apart from the cycle that follows a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| mem_addr | output | ADDR_W | Memory byte address: the pointer, or the commit address during a write cycle |
| mem_we | output | 1 | Memory write strobe, one byte per clock |
| mem_wdata | output | 8 | Byte to be written |
| mem_rdata | input | 8 | Byte at mem_addr, combinational read |

## Verification
The block is driven with single-byte writes, page writes that wrap and overwrite, and several kinds of read. The reads include a random read, a sequential run that crosses the top of memory, current-address reads and a read after an address-only write. Comparing these reads shows whether the pointer is shared and kept across transactions, and whether it wraps at the page in writes and at the whole memory in reads. Headers with a wrong type field, and polls sent during the write cycle, show whether the acknowledge is withheld for the right reason. Polls sent after the cycle show that it is given again.

// File: rtl/eep_pkg.sv
package eep_pkg;

  parameter logic [3:0] EEP_DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_HACK,
    ST_WADR,
    ST_WACK,
    ST_WDAT,
    ST_DACK,
    ST_RDAT,
    ST_RACK
  } eep_state_e;

endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // SDA edges while SCL stays high mark bus conditions
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [7:0]               wr_data,
  input  logic                     clr,
  input  logic [PAGE_W-1:0]        rd_idx,
  output logic [ADDR_W-PAGE_W-1:0] row,
  output logic [7:0]               rd_data,
  output logic                     rd_valid,
  output logic                     any_valid
);

  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [PAGE_BYTES-1:0][7:0] data_q;
  logic [PAGE_BYTES-1:0]      valid_q;
  logic [ADDR_W-PAGE_W-1:0]   row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= '0;
      row_q   <= '0;
    end else if (clr) begin
      valid_q <= '0;
    end else if (wr_en) begin
      row_q <= wr_addr[ADDR_W-1:PAGE_W];
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (wr_addr[PAGE_W-1:0] == PAGE_W'(i)) begin
          data_q[i]  <= wr_data;
          valid_q[i] <= 1'b1;
        end
      end
    end
  end

  assign row       = row_q;
  assign rd_data   = data_q[rd_idx];
  assign rd_valid  = valid_q[rd_idx];
  assign any_valid = |valid_q;

  // R4: once a page holds data, later bytes of the same write target that page
  p_row_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && any_valid) |-> (wr_addr[ADDR_W-1:PAGE_W] == row_q));

endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int PAGE_W  = 3,
  parameter int TWR_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              busy,
  output logic              commit,
  output logic              done,
  output logic [PAGE_W-1:0] idx
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TOTAL      = PAGE_BYTES + TWR_CYC;
  localparam int CW         = $clog2(TOTAL + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (go) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done   = busy && (cnt_q == CW'(TOTAL - 1));
  assign commit = busy && (cnt_q < CW'(PAGE_BYTES));
  assign idx    = cnt_q[PAGE_W-1:0];

  // R5: a new write cycle is only launched from the idle state
  p_go_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
  p_go_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target
  import eep_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PAGE_W  = 3,
  parameter int TWR_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  localparam int ROW_W = ADDR_W - PAGE_W;

  function automatic logic hdr_ok(input logic [7:0] b);
    return b[7:4] == EEP_DEV_TYPE;
  endfunction

  function automatic logic [ADDR_W-1:0] page_inc(input logic [ADDR_W-1:0] a);
    logic [PAGE_W-1:0] lo;
    lo = a[PAGE_W-1:0] + 1'b1;
    return {a[ADDR_W-1:PAGE_W], lo};
  endfunction

  // bus events
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  eep_bus_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  // write cycle and page buffer
  logic              busy, commit, wc_done, go;
  logic [PAGE_W-1:0] wc_idx;
  logic [ROW_W-1:0]  buf_row;
  logic [7:0]        buf_rdata;
  logic              buf_rvalid, buf_any, buf_we;

  eep_wr_timer #(.PAGE_W(PAGE_W), .TWR_CYC(TWR_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .commit(commit),
    .done(wc_done), .idx(wc_idx)
  );

  eep_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) pbuf_i (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_we), .wr_addr(ptr_q_w),
    .wr_data(sh_q_w), .clr(wc_done), .rd_idx(wc_idx), .row(buf_row),
    .rd_data(buf_rdata), .rd_valid(buf_rvalid), .any_valid(buf_any)
  );

  // protocol state
  eep_state_e        state_q;
  logic [3:0]        bit_q;
  logic [7:0]        sh_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              rd_q, mack_q;
  logic [ADDR_W-1:0] ptr_q_w;
  logic [7:0]        sh_q_w;

  assign ptr_q_w = ptr_q;
  assign sh_q_w  = sh_q;

  logic rx_state, rx_bit_ev, rx_done_ev, quiet;
  assign rx_state   = (state_q == ST_HDR) || (state_q == ST_WADR) || (state_q == ST_WDAT);
  assign rx_bit_ev  = scl_rise && (bit_q != 4'd8);
  assign rx_done_ev = scl_fall && (bit_q == 4'd8);
  assign quiet      = busy || start_ev || stop_ev;
  assign buf_we     = (state_q == ST_WDAT) && rx_done_ev && !quiet;
  assign go         = stop_ev && buf_any && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else if (busy || stop_ev) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
    end else if (start_ev) begin
      state_q <= ST_HDR;
      bit_q   <= '0;
    end else begin
      unique case (state_q)
        ST_HDR, ST_WADR, ST_WDAT: begin
          if (rx_bit_ev) begin
            sh_q  <= {sh_q[6:0], sda_s};
            bit_q <= bit_q + 4'd1;
          end else if (rx_done_ev) begin
            bit_q <= '0;
            if (state_q == ST_HDR) begin
              if (hdr_ok(sh_q)) begin
                state_q <= ST_HACK;
                rd_q    <= sh_q[0];
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_WADR) begin
              ptr_q   <= ADDR_W'(sh_q);
              state_q <= ST_WACK;
            end else begin
              ptr_q   <= page_inc(ptr_q);
              state_q <= ST_DACK;
            end
          end
        end
        ST_HACK: begin
          if (scl_fall) begin
            if (rd_q) begin
              sh_q    <= mem_rdata;
              state_q <= ST_RDAT;
            end else begin
              state_q <= ST_WADR;
            end
          end
        end
        ST_WACK, ST_DACK: begin
          if (scl_fall) state_q <= ST_WDAT;
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              bit_q   <= '0;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_RACK;
            end else begin
              sh_q  <= {sh_q[6:0], 1'b0};
              bit_q <= bit_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) mack_q <= !sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              sh_q    <= mem_rdata;
              state_q <= ST_RDAT;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_HACK, ST_WACK, ST_DACK: sda_oe = 1'b1;
      ST_RDAT:                   sda_oe = !sh_q[7];
      default:                   sda_oe = 1'b0;
    endcase
  end

  assign mem_addr  = busy ? {buf_row, wc_idx} : ptr_q;
  assign mem_we    = commit && buf_rvalid;
  assign mem_wdata = buf_rdata;

  // R5: while the write cycle runs the target stays off the bus
  p_quiet_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
  // R3: memory is written only inside a write cycle
  p_commit_in_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R1: a header acknowledge needs the right type field
  p_hack_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HACK) |-> (sh_q[7:4] == EEP_DEV_TYPE));
  // R9: a master NACK releases the line
  p_nack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RACK && scl_fall && !mack_q && !rx_state) |=> !sda_oe);
  // R11: drive is steady while SCL is high
  p_oe_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));

endmodule

// File: tb/eep_i2c_target_tb_top.sv
`timescale 1ns/1ps
module eep_i2c_target_tb_top;

  localparam int ADDR_W  = 8;
  localparam int PAGE_W  = 3;
  localparam int TWR_CYC = 200;
  localparam int MEMSZ   = 1 << ADDR_W;
  localparam int QT = 5;
  localparam int HT = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic sda_line;

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  eep_i2c_target #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TWR_CYC(TWR_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory behind the port and the bench's own expectation of it
  logic [7:0] mem [MEMSZ];
  logic [7:0] shadow [MEMSZ];
  int ptr = 0;

  assign mem_rdata = mem[mem_addr];
  always_ff @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  logic [7:0] mon_byte;
  string mon_req = "R6";
  event byte_ev;

  initial begin
    forever begin
      @(byte_ev);
      if (exp_q.size() == 0) chk(1'b0, mon_req, int'(mon_byte), -1);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(mon_byte == e, mon_req, int'(mon_byte), int'(e));
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1; wclk(QT);
    m_sda = 1'b0; wclk(QT);
    m_scl = 1'b0; wclk(QT);
  endtask

  task automatic m_rstart();
    m_sda = 1'b1; wclk(QT);
    m_scl = 1'b1; wclk(QT);
    m_sda = 1'b0; wclk(QT);
    m_scl = 1'b0; wclk(QT);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; wclk(QT);
    m_scl = 1'b1; wclk(QT);
    m_sda = 1'b1; wclk(QT);
  endtask

  task automatic m_bit_w(input logic b);
    m_sda = b; wclk(QT);
    m_scl = 1'b1; wclk(HT);
    m_scl = 1'b0; wclk(QT);
  endtask

  task automatic m_bit_r(input bit hold_chk, output logic b);
    logic s1, s2;
    m_sda = 1'b1; wclk(QT);
    m_scl = 1'b1; wclk(HT/2);
    s1 = sda_line; wclk(HT/2);
    s2 = sda_line;
    if (hold_chk) chk(s1 == s2, "R11", int'(s2), int'(s1));
    b = s1;
    m_scl = 1'b0; wclk(QT);
  endtask

  task automatic m_wbyte(input logic [7:0] d, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
    m_bit_r(1'b0, a);
    acked = !a;
  endtask

  task automatic m_rbyte(input bit mack, output logic [7:0] d);
    logic b;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      m_bit_r(1'b1, b);
      d = {d[6:0], b};
    end
    m_bit_w(!mack);
    mon_byte = d;
    -> byte_ev;
  endtask

  // read n bytes at the current pointer; expectations go to the queue first
  task automatic rd_run(input int n, input string req);
    logic [7:0] d;
    mon_req = req;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(shadow[ptr]);
      ptr = (ptr + 1) % MEMSZ;
    end
    for (int i = 0; i < n; i++) m_rbyte(i != n - 1, d);
    chk(sda_oe == 1'b0, "R9", int'(sda_oe), 0);
  endtask

  // poll until the header is taken; checks that the first poll is refused
  task automatic poll_done();
    bit a;
    int polls = 0;
    bit got = 1'b0;
    while (!got && polls < 40) begin
      m_start();
      m_wbyte(8'hA0, a);
      m_stop();
      if (polls == 0) chk(!a, "R5", int'(a), 0);
      got = a;
      polls++;
    end
    chk(got, "R5", int'(got), 1);
  endtask

  task automatic wr_bytes(input logic [7:0] addr, input int n, input logic [7:0] seed);
    bit a;
    int p;
    m_start();
    m_wbyte(8'hA0, a); chk(a, "R2", int'(a), 1);
    m_wbyte(addr, a);  chk(a, "R2", int'(a), 1);
    p = int'(addr);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      v = seed + 8'(i * 13);
      m_wbyte(v, a); chk(a, "R2", int'(a), 1);
      shadow[p] = v;
      p = (p & ~((1 << PAGE_W) - 1)) | ((p + 1) & ((1 << PAGE_W) - 1));
    end
    m_stop();
    ptr = p;
  endtask

  task automatic set_addr(input logic [7:0] addr);
    bit a;
    m_start();
    m_wbyte(8'hA0, a); chk(a, "R1", int'(a), 1);
    m_wbyte(addr, a);  chk(a, "R2", int'(a), 1);
    ptr = int'(addr);
  endtask

  initial begin
    bit a;
    for (int i = 0; i < MEMSZ; i++) begin
      mem[i]    = 8'((i * 37 + 11) & 255);
      shadow[i] = 8'((i * 37 + 11) & 255);
    end
    wclk(4);
    chk(sda_oe == 1'b0, "R11", int'(sda_oe), 0);
    chk(mem_we == 1'b0, "R5", int'(mem_we), 0);
    rst_n = 1'b1;
    wclk(5);

    // R1: wrong type fields are refused
    m_start(); m_wbyte(8'h52, a); m_stop(); chk(!a, "R1", int'(a), 0);
    m_start(); m_wbyte(8'hB0, a); m_stop(); chk(!a, "R1", int'(a), 0);

    // R3: single byte write, then poll, then random read back (R7)
    wr_bytes(8'h10, 1, 8'h5A);
    poll_done();
    set_addr(8'h10);
    m_rstart(); m_wbyte(8'hA1, a); chk(a, "R7", int'(a), 1);
    rd_run(1, "R3");
    m_stop();

    // R4: ten bytes from offset 5 wrap inside the page 0x18..0x1F
    wr_bytes(8'h1D, 10, 8'h80);
    poll_done();
    set_addr(8'h18);
    m_rstart(); m_wbyte(8'hA1, a); chk(a, "R7", int'(a), 1);
    rd_run(8, "R4");
    m_stop();

    // R6: current address read continues from the pointer
    m_start(); m_wbyte(8'hA1, a); chk(a, "R6", int'(a), 1);
    rd_run(1, "R6");
    m_stop();
    // R1: chip-select bits are don't-care
    m_start(); m_wbyte(8'hAF, a); chk(a, "R1", int'(a), 1);
    rd_run(2, "R6");
    m_stop();

    // R8: sequential read across the top of memory
    set_addr(8'hFD);
    m_rstart(); m_wbyte(8'hA1, a); chk(a, "R7", int'(a), 1);
    rd_run(5, "R8");
    m_stop();

    // R10: address-only write starts no cycle; next header taken at once
    set_addr(8'h40);
    m_stop();
    m_start(); m_wbyte(8'hA1, a); chk(a, "R10", int'(a), 1);
    rd_run(2, "R10");
    m_stop();

    wclk(20);
    chk(exp_q.size() == 0, "R8", exp_q.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule